// File: doc/BRIEF.md
# Multi-Enable Interrupt Source Aggregator

This block watches a parameterised set of level-sensitive interrupt sources and folds them into one interrupt request towards the CPU, together with a vector for the request. A source is not switched on by a single mask bit. Each source has a small enable counter and a fixed per-source required count. The source counts as enabled only while its counter equals that required count. Several independent registers or groups can therefore each grant or withdraw a share of the enable. Increment and decrement strobes for each counter come from a separate register block.

A source is pending while its registered input is asserted and it is enabled. The block keeps a running count of pending sources and holds the CPU request high while that count is non-zero. When the CPU interrupt mask is not all ones, the vector output gives the vector of the lowest-numbered pending source, and a valid flag qualifies it. Source vectors are spaced evenly from a base value.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is low and on the first cycle after it, every enable counter, asserted flag and pending flag is zero, `cpuIrq` is 0, `vecValid` is 0 and `vecOut` is 0.
- R2: A lone increment strobe raises a source's enable counter by one and a lone decrement strobe lowers it by one, both on the next clock edge. Both strobes in the same cycle leave the counter unchanged. The counter saturates at 0 and at 2^CNT_W-1.
- R3: A source is enabled only when its counter equals its required count (bits `[i*CNT_W +: CNT_W]` of `REQ_CNT`). A counter above the required count does not enable it, and a required count of 0 means the source is enabled out of reset.
- R4: A source's pending flag is its asserted flag ANDed with its enable condition, both taken after the same clock edge, so pending is re-evaluated on every enable or assert change.
- R5: A source's asserted flag takes the value of its `srcLevel` bit at each clock edge. A level that stays the same produces no change.
- R6: `cpuIrq` is high exactly while the count of pending sources is above zero. It rises when the count leaves 0 and falls when the count returns to 0.
- R7: With `vecValid` high, `vecOut` equals `VEC_BASE + i*VEC_STEP`, where i is the lowest index of a pending source.
- R8: When `cpuMask` equals 4'hF, `vecValid` and `vecOut` are 0 in the same cycle, while `cpuIrq` keeps following the pending count.
- R9: When no source is pending, `vecValid` is 0 and `vecOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcLevel | input | NUM_SRC | Level of each interrupt source |
| enInc | input | NUM_SRC | Single-cycle enable grant strobe per source |
| enDec | input | NUM_SRC | Single-cycle enable withdraw strobe per source |
| cpuMask | input | 4 | CPU interrupt mask level; 4'hF blocks the vector |
| cpuIrq | output | 1 | Interrupt request towards the CPU |
| vecValid | output | 1 | `vecOut` holds the vector of a pending source |
| vecOut | output | VEC_W | Vector of the lowest-numbered pending source |

## Verification
The bench builds the block with six sources and 2-bit counters. The required counts are 2, 1, 0, 2, 1 and 3. This set covers a source that is enabled with no grants at all, and it places one required count at the saturation value, so the saturation rule and the "equal, not above" rule can be seen through the pending state. Twelve-bit vectors with base 0x200 and step 0x20 make each source's vector distinct, so the lowest-index choice is checked directly. With only six sources, random level, strobe and mask traffic regularly produces several pending sources at once and also brings the global count back to zero.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Per-source strobes from control to datapath
  typedef struct packed {
    logic assertUp;
    logic assertDn;
    logic enUp;
    logic enDn;
  } srcStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [NUM_SRC-1:0] enInc,
  input  logic [NUM_SRC-1:0] enDec,
  input  logic [NUM_SRC-1:0] assertVec,
  output srcStrobe_t [NUM_SRC-1:0] strobes
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_comb begin
      strobes[i].assertUp = srcLevel[i] & ~assertVec[i];
      strobes[i].assertDn = ~srcLevel[i] & assertVec[i];
      strobes[i].enUp     = enInc[i] & ~enDec[i];
      strobes[i].enDn     = enDec[i] & ~enInc[i];
    end
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 3,
  parameter logic [NUM_SRC*CNT_W-1:0] REQ_CNT = {NUM_SRC{CNT_W'(1)}}
) (
  input  logic clk,
  input  logic rstN,
  input  srcStrobe_t [NUM_SRC-1:0] strobes,
  output logic [NUM_SRC-1:0] assertVec,
  output logic [NUM_SRC-1:0] pendVec,
  output logic [NUM_SRC*CNT_W-1:0] enCntFlat,
  output logic cpuIrq
);

  localparam int PCNT_W = $clog2(NUM_SRC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_SRC-1:0] assertNext;
  logic [NUM_SRC-1:0] pendNext;
  logic [NUM_SRC*CNT_W-1:0] cntNext;
  logic [PCNT_W-1:0] pendCnt;
  logic [PCNT_W-1:0] pendCntNext;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CNT_W-1:0] cur;
    assign cur = enCntFlat[i*CNT_W +: CNT_W];
    always_comb begin
      cntNext[i*CNT_W +: CNT_W] = cur;
      if (strobes[i].enUp && cur != CNT_MAX)
        cntNext[i*CNT_W +: CNT_W] = cur + CNT_W'(1);
      else if (strobes[i].enDn && cur != '0)
        cntNext[i*CNT_W +: CNT_W] = cur - CNT_W'(1);
      assertNext[i] = assertVec[i];
      if (strobes[i].assertUp) assertNext[i] = 1'b1;
      else if (strobes[i].assertDn) assertNext[i] = 1'b0;
      pendNext[i] = assertNext[i] &&
                    (cntNext[i*CNT_W +: CNT_W] == REQ_CNT[i*CNT_W +: CNT_W]);
    end
  end

  // Running pending count: up on a rise, down on a fall
  always_comb begin
    pendCntNext = pendCnt;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendNext[i] && !pendVec[i]) pendCntNext = pendCntNext + PCNT_W'(1);
      else if (!pendNext[i] && pendVec[i]) pendCntNext = pendCntNext - PCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enCntFlat <= '0;
      assertVec <= '0;
      pendVec   <= '0;
      pendCnt   <= '0;
      cpuIrq    <= 1'b0;
    end else begin
      enCntFlat <= cntNext;
      assertVec <= assertNext;
      pendVec   <= pendNext;
      pendCnt   <= pendCntNext;
      cpuIrq    <= (pendCntNext != '0);
    end
  end

endmodule

// File: rtl/irq_agg_vecpick.sv
module irq_agg_vecpick #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] VEC_BASE = 12'h200,
  parameter logic [VEC_W-1:0] VEC_STEP = 12'h20
) (
  input  logic [NUM_SRC-1:0] pendVec,
  input  logic [3:0] cpuMask,
  output logic vecValid,
  output logic [VEC_W-1:0] vecOut
);

  logic [VEC_W-1:0] pick;
  logic found;

  // Descending walk so the lowest index is written last and wins
  always_comb begin
    pick = '0;
    found = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        pick = VEC_BASE + VEC_W'(i) * VEC_STEP;
        found = 1'b1;
      end
    end
    vecValid = found && (cpuMask != 4'hF);
    vecOut = vecValid ? pick : '0;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 3,
  parameter logic [NUM_SRC*CNT_W-1:0] REQ_CNT = {NUM_SRC{CNT_W'(1)}},
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] VEC_BASE = 12'h200,
  parameter logic [VEC_W-1:0] VEC_STEP = 12'h20
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_SRC-1:0] srcLevel,
  input  logic [NUM_SRC-1:0] enInc,
  input  logic [NUM_SRC-1:0] enDec,
  input  logic [3:0] cpuMask,
  output logic cpuIrq,
  output logic vecValid,
  output logic [VEC_W-1:0] vecOut
);

  srcStrobe_t [NUM_SRC-1:0] strobes;
  logic [NUM_SRC-1:0] assertVec;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC*CNT_W-1:0] enCntFlat;

  irq_agg_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .srcLevel(srcLevel), .enInc(enInc), .enDec(enDec),
    .assertVec(assertVec), .strobes(strobes)
  );

  irq_agg_datapath #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .REQ_CNT(REQ_CNT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .assertVec(assertVec),
    .pendVec(pendVec), .enCntFlat(enCntFlat), .cpuIrq(cpuIrq)
  );

  irq_agg_vecpick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                    .VEC_STEP(VEC_STEP)) u_pick (
    .pendVec(pendVec), .cpuMask(cpuMask), .vecValid(vecValid), .vecOut(vecOut)
  );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_SRC = 8,
  parameter int CNT_W = 3,
  parameter int VEC_W = 12
) (
  input logic clk,
  input logic rstN,
  input logic [NUM_SRC-1:0] srcLevel,
  input logic [NUM_SRC-1:0] enInc,
  input logic [NUM_SRC-1:0] enDec,
  input logic [3:0] cpuMask,
  input logic cpuIrq,
  input logic vecValid,
  input logic [VEC_W-1:0] vecOut,
  input logic [NUM_SRC-1:0] assertVec,
  input logic [NUM_SRC-1:0] pendVec,
  input logic [NUM_SRC*CNT_W-1:0] enCntFlat
);

  AST_IRQ_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (pendVec != '0)); // R6

  AST_MASK_BLOCKS_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMask == 4'hF) |-> (!vecValid && vecOut == '0)); // R8

  AST_IDLE_NO_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    !cpuIrq |-> (!vecValid && vecOut == '0)); // R9

  AST_ASSERT_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> assertVec == $past(srcLevel)); // R5

  AST_PENDING_NEEDS_ASSERT: assert property (@(posedge clk) disable iff (!rstN)
    (pendVec & ~assertVec) == '0); // R4

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    AST_BOTH_STROBES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (enInc[i] && enDec[i]) |=> $stable(enCntFlat[i*CNT_W +: CNT_W])); // R2
  end

endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .VEC_W(VEC_W)) i_chk (
  .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .enInc(enInc), .enDec(enDec),
  .cpuMask(cpuMask), .cpuIrq(cpuIrq), .vecValid(vecValid), .vecOut(vecOut),
  .assertVec(assertVec), .pendVec(pendVec), .enCntFlat(enCntFlat)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  localparam int NS = 6;
  localparam int CW = 2;
  localparam int VW = 12;
  localparam int MAXC = 3;
  localparam int BASE = 'h200;
  localparam int STEP = 'h20;
  // required counts, source 5 down to source 0: 3,1,2,0,1,2
  localparam logic [NS*CW-1:0] REQ = {2'd3, 2'd1, 2'd2, 2'd0, 2'd1, 2'd2};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] srcLevel = '0;
  logic [NS-1:0] enInc = '0;
  logic [NS-1:0] enDec = '0;
  logic [3:0] cpuMask = 4'h0;
  logic cpuIrq, vecValid;
  logic [VW-1:0] vecOut;

  int nChk = 0;
  int nBad = 0;
  int enc [NS];
  int asrt [NS];
  int pend [NS];
  int req [NS];

  always #5 clk = ~clk;

  irq_aggregator #(.NUM_SRC(NS), .CNT_W(CW), .REQ_CNT(REQ), .VEC_W(VW),
                   .VEC_BASE(12'h200), .VEC_STEP(12'h20)) i_irq_aggregator (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .enInc(enInc), .enDec(enDec),
    .cpuMask(cpuMask), .cpuIrq(cpuIrq), .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < NS; i++) begin
      enc[i] = 0; asrt[i] = 0; pend[i] = 0;
      req[i] = int'(REQ[i*CW +: CW]);
    end
  endtask

  task automatic modelStep();
    for (int i = 0; i < NS; i++) begin
      if (enInc[i] && !enDec[i] && enc[i] < MAXC) enc[i]++;
      else if (enDec[i] && !enInc[i] && enc[i] > 0) enc[i]--;
      asrt[i] = int'(srcLevel[i]);
      pend[i] = (asrt[i] != 0 && enc[i] == req[i]) ? 1 : 0;
    end
  endtask

  task automatic compareModel();
    int first = -1;
    int expValid;
    for (int i = NS - 1; i >= 0; i--) if (pend[i] != 0) first = i;
    expValid = (first >= 0 && cpuMask != 4'hF) ? 1 : 0;
    chk("R6 cpuIrq", int'(cpuIrq), first >= 0 ? 1 : 0);
    chk("R8/R9 vecValid", int'(vecValid), expValid);
    chk("R7 vecOut", int'(vecOut), expValid != 0 ? BASE + first * STEP : 0);
  endtask

  // one clock: model follows the edge, compare at the falling edge
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareModel();
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(cpuIrq), 0);
    chk("R1 valid in reset", int'(vecValid), 0);
    rstN = 1'b1;
    tick();
    chk("R1 vecOut after reset", int'(vecOut), 0);
    chk("R9 idle valid", int'(vecValid), 0);

    // R5/R4: source 2 needs zero grants, so pending one edge after level rises
    srcLevel[2] = 1'b1;
    tick();
    chk("R4 src2 irq", int'(cpuIrq), 1);
    chk("R7 src2 vector", int'(vecOut), 'h240);

    // R3: source 1 needs one grant
    srcLevel[1] = 1'b1;
    tick();
    chk("R3 src1 not yet enabled", int'(vecOut), 'h240);
    enInc[1] = 1'b1;
    tick();
    enInc[1] = 1'b0;
    chk("R3 src1 enabled at equal count", int'(vecOut), 'h220);

    // R8: mask all ones hides vector, irq stays
    cpuMask = 4'hF;
    tick();
    chk("R8 masked valid", int'(vecValid), 0);
    chk("R8 masked irq", int'(cpuIrq), 1);
    cpuMask = 4'h3;

    // R3: a count above the required one disables
    enInc[1] = 1'b1;
    tick();
    enInc[1] = 1'b0;
    chk("R3 src1 above count", int'(vecOut), 'h240);

    // R2: both strobes leave the counter alone
    enInc[1] = 1'b1; enDec[1] = 1'b1;
    tick();
    enInc[1] = 1'b0; enDec[1] = 1'b0;
    chk("R2 both strobes", int'(vecOut), 'h240);
    enDec[1] = 1'b1;
    tick();
    enDec[1] = 1'b0;
    chk("R2 decrement restores", int'(vecOut), 'h220);

    // R2: saturation of source 5 at 3, which is its required count
    srcLevel[1] = 1'b0; srcLevel[2] = 1'b0; srcLevel[5] = 1'b1;
    enInc[5] = 1'b1;
    repeat (5) tick();
    enInc[5] = 1'b0;
    tick();
    chk("R2 saturate high", int'(vecOut), 'h2A0);
    enDec[5] = 1'b1;
    tick();
    enDec[5] = 1'b0;
    chk("R6 irq falls", int'(cpuIrq), 0);
    enDec[5] = 1'b1;
    repeat (5) tick();
    enDec[5] = 1'b0;
    srcLevel[5] = 1'b0;
    tick();

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      srcLevel = ($urandom_range(0, 3) == 0) ? NS'($urandom) : srcLevel;
      enInc = NS'($urandom) & NS'($urandom);
      enDec = NS'($urandom) & NS'($urandom);
      cpuMask = ($urandom_range(0, 7) == 0) ? 4'hF : 4'($urandom_range(0, 14));
      tick();
    end

    // R1: reset mid-run clears everything
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    chk("R1 irq after reset", int'(cpuIrq), 0);
    chk("R1 valid after reset", int'(vecValid), 0);
    finishRun();
  end

endmodule